// File: doc/BRIEF.md
# Hot-Plug-Detect Receive Debouncer

This block watches the hot-plug-detect line arriving from a DisplayPort sink-side link and turns its raw transitions into clean, classified events. The raw line is first brought into the local clock domain, then a small state machine measures how long each level persists. A level that rises and stays high long enough becomes a debounced connection. A short low-going excursion from the connected state is an interrupt request from the sink. A low that outlasts the low-debounce window is a genuine unplug.

Every timer length is a parameter counted in clock ticks. A select input picks one of two high-debounce lengths. Outputs are a debounced level and three single-cycle event strobes: interrupt, connect and disconnect. All of them come from registers.

Top module: `hpd_rx_debounce`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `hpd_level` is 0 and all three strobes are 0.
- R2: `hpd_in` passes through a two-flop synchroniser. If `hpd_in` is high at clock edge k and stays high, `connect_pulse` and the rise of `hpd_level` appear at edge k+1+N, where N is the selected high-debounce length.
- R3: With `hi_db_sel` = 0, N is `HI_DB_SHORT`. With `hi_db_sel` = 1, N is `HI_DB_LONG`.
- R4: While disconnected, a high excursion of fewer than N sampled cycles produces no event and leaves `hpd_level` at 0. The next rise must again last N full cycles.
- R5: While connected, a low excursion of fewer than `IRQ_LIMIT` sampled cycles produces `irq_pulse` two cycles after `hpd_in` returns high, and `hpd_level` stays 1.
- R6: While connected, a low excursion of at least `IRQ_LIMIT` and fewer than `LO_DB` sampled cycles produces no event, and `hpd_level` stays 1. `LO_DB` must exceed `IRQ_LIMIT`.
- R7: While connected, if `hpd_in` goes low at edge k and stays low, `disconnect_pulse` and the fall of `hpd_level` appear at edge k+1+`LO_DB`.
- R8: Each strobe lasts exactly one cycle. At most one strobe is high in any cycle. `hpd_level` rises only together with `connect_pulse` and falls only together with `disconnect_pulse`.
- R9: While connected, every qualifying short low excursion raises its own interrupt. `irq_pulse` is never raised while `hpd_level` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hpd_in | input | 1 | Raw hot-plug-detect line, asynchronous |
| hi_db_sel | input | 1 | Picks the high-debounce length: 0 short, 1 long |
| hpd_level | output | 1 | Debounced connection level |
| irq_pulse | output | 1 | One-cycle interrupt-request event |
| connect_pulse | output | 1 | One-cycle connect event |
| disconnect_pulse | output | 1 | One-cycle disconnect event |

## Verification
A level that starts at edge k passes two synchroniser flops and then one registered classifier. A connect therefore lands at edge k+1+N and a disconnect at edge k+1+`LO_DB`. An interrupt lands two edges after the line returns high. The bench drives inputs on falling edges and counts falling edges from the drive point. It checks the strobe one edge before its due edge, where it must be 0, then on its due edge, where it must be 1, then one edge after, where it must be 0 again. Excursions are tested just below and exactly at each limit. A monitor totals strobes and overlaps so that missing, extra or coincident events are caught.

// File: rtl/hpd_rx_pkg.sv
package hpd_rx_pkg;

  typedef enum logic [2:0] {
    ST_DOWN    = 3'd0,
    ST_RISING  = 3'd1,
    ST_UP      = 3'd2,
    ST_DIP     = 3'd3,
    ST_FALLING = 3'd4
  } hpd_state_t;

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/hpd_sync.sv
module hpd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hpd_run_counter.sv
module hpd_run_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_one,
  input  logic          incr,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)           count <= '0;
    else if (load_one) count <= CW'(1);
    else if (incr)     count <= count + CW'(1);
  end
endmodule

// File: rtl/hpd_classifier.sv
module hpd_classifier
  import hpd_rx_pkg::*;
#(
  parameter int HI_DB_SHORT = 100,
  parameter int HI_DB_LONG  = 200,
  parameter int IRQ_LIMIT   = 150,
  parameter int LO_DB       = 200,
  parameter int CW          = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line,
  input  logic          sel,
  input  logic [CW-1:0] count,
  output logic          load_one,
  output logic          incr,
  output logic          level,
  output logic          irq,
  output logic          conn,
  output logic          disc
);
  hpd_state_t state, state_nx;
  logic level_nx, irq_nx, conn_nx, disc_nx;
  int run_nx;
  int hi_limit;

  assign run_nx   = int'(count) + 1;
  assign hi_limit = sel ? HI_DB_LONG : HI_DB_SHORT;

  always_comb begin
    state_nx = state;
    level_nx = level;
    irq_nx   = 1'b0;
    conn_nx  = 1'b0;
    disc_nx  = 1'b0;
    load_one = 1'b0;
    incr     = 1'b0;
    case (state)
      ST_DOWN: begin
        if (line) begin
          if (hi_limit <= 1) begin
            state_nx = ST_UP;
            level_nx = 1'b1;
            conn_nx  = 1'b1;
          end else begin
            state_nx = ST_RISING;
            load_one = 1'b1;
          end
        end
      end
      ST_RISING: begin
        if (!line) begin
          state_nx = ST_DOWN;
        end else if (run_nx >= hi_limit) begin
          state_nx = ST_UP;
          level_nx = 1'b1;
          conn_nx  = 1'b1;
        end else begin
          incr = 1'b1;
        end
      end
      ST_UP: begin
        if (!line) begin
          state_nx = (IRQ_LIMIT <= 1) ? ST_FALLING : ST_DIP;
          load_one = 1'b1;
        end
      end
      ST_DIP: begin
        if (line) begin
          state_nx = ST_UP;
          irq_nx   = 1'b1;
        end else begin
          incr = 1'b1;
          if (run_nx >= IRQ_LIMIT) state_nx = ST_FALLING;
        end
      end
      ST_FALLING: begin
        if (line) begin
          state_nx = ST_UP;
        end else if (run_nx >= LO_DB) begin
          state_nx = ST_DOWN;
          level_nx = 1'b0;
          disc_nx  = 1'b1;
        end else begin
          incr = 1'b1;
        end
      end
      default: begin
        state_nx = ST_DOWN;
        level_nx = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_DOWN;
      level <= 1'b0;
      irq   <= 1'b0;
      conn  <= 1'b0;
      disc  <= 1'b0;
    end else begin
      state <= state_nx;
      level <= level_nx;
      irq   <= irq_nx;
      conn  <= conn_nx;
      disc  <= disc_nx;
    end
  end
endmodule

// File: rtl/hpd_rx_debounce.sv
module hpd_rx_debounce
  import hpd_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HI_DB_SHORT = 100,
  parameter int HI_DB_LONG  = 200,
  parameter int IRQ_LIMIT   = 150,
  parameter int LO_DB       = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic hpd_in,
  input  logic hi_db_sel,
  output logic hpd_level,
  output logic irq_pulse,
  output logic connect_pulse,
  output logic disconnect_pulse
);
  localparam int MAX_TICKS = max_of4(HI_DB_SHORT, HI_DB_LONG, IRQ_LIMIT, LO_DB);
  localparam int CW        = $clog2(MAX_TICKS + 1);

  logic          line_s;
  logic          ld_one, inc;
  logic [CW-1:0] run_count;

  hpd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (hpd_in),
    .q   (line_s)
  );

  hpd_run_counter #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load_one (ld_one),
    .incr     (inc),
    .count    (run_count)
  );

  hpd_classifier #(
    .HI_DB_SHORT (HI_DB_SHORT),
    .HI_DB_LONG  (HI_DB_LONG),
    .IRQ_LIMIT   (IRQ_LIMIT),
    .LO_DB       (LO_DB),
    .CW          (CW)
  ) u_cls (
    .clk      (clk),
    .rst      (rst),
    .line     (line_s),
    .sel      (hi_db_sel),
    .count    (run_count),
    .load_one (ld_one),
    .incr     (inc),
    .level    (hpd_level),
    .irq      (irq_pulse),
    .conn     (connect_pulse),
    .disc     (disconnect_pulse)
  );
endmodule

// File: rtl/hpd_rx_debounce_chk.sv
module hpd_rx_debounce_chk (
  input logic clk,
  input logic rst,
  input logic hpd_level,
  input logic irq_pulse,
  input logic connect_pulse,
  input logic disconnect_pulse
);
  // R8
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({irq_pulse, connect_pulse, disconnect_pulse}) <= 1);

  // R8
  level_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hpd_level) |-> connect_pulse);

  // R8
  level_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(hpd_level) |-> disconnect_pulse);

  // R8
  irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |=> !irq_pulse);

  // R8
  conn_single_chk: assert property (@(posedge clk) disable iff (rst)
    connect_pulse |=> !connect_pulse);

  // R9
  irq_when_up_chk: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> hpd_level);

  // R8
  disc_drops_chk: assert property (@(posedge clk) disable iff (rst)
    disconnect_pulse |-> !hpd_level);
endmodule

bind hpd_rx_debounce hpd_rx_debounce_chk u_chk (
  .clk              (clk),
  .rst              (rst),
  .hpd_level        (hpd_level),
  .irq_pulse        (irq_pulse),
  .connect_pulse    (connect_pulse),
  .disconnect_pulse (disconnect_pulse)
);

// File: tb/hpd_rx_debounce_bench.sv
module hpd_rx_debounce_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HS  = 8;
  localparam int HL  = 20;
  localparam int IRQ = 12;
  localparam int LDB = 30;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hpd_in = 1'b0;
  logic hi_db_sel = 1'b0;
  logic hpd_level, irq_pulse, connect_pulse, disconnect_pulse;

  int checks = 0;
  int fails  = 0;
  int n_irq = 0, n_con = 0, n_dis = 0, n_overlap = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hpd_rx_debounce #(
    .HI_DB_SHORT (HS),
    .HI_DB_LONG  (HL),
    .IRQ_LIMIT   (IRQ),
    .LO_DB       (LDB)
  ) u_hpd_rx_debounce (
    .clk              (clk),
    .rst              (rst),
    .hpd_in           (hpd_in),
    .hi_db_sel        (hi_db_sel),
    .hpd_level        (hpd_level),
    .irq_pulse        (irq_pulse),
    .connect_pulse    (connect_pulse),
    .disconnect_pulse (disconnect_pulse)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (!rst) begin
      if (irq_pulse)        n_irq <= n_irq + 1;
      if (connect_pulse)    n_con <= n_con + 1;
      if (disconnect_pulse) n_dis <= n_dis + 1;
      if (int'(irq_pulse) + int'(connect_pulse) + int'(disconnect_pulse) > 1)
        n_overlap <= n_overlap + 1;
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic t_reset();
    rst = 1'b1; hpd_in = 1'b0;
    tick(4);
    chk("R1 level in reset", int'(hpd_level), 0);
    chk("R1 strobes in reset", int'(irq_pulse | connect_pulse | disconnect_pulse), 0);
    rst = 1'b0;
    tick(1);
    chk("R1 level after reset", int'(hpd_level), 0);
    chk("R1 strobes after reset", int'(irq_pulse | connect_pulse | disconnect_pulse), 0);
  endtask

  task automatic t_glitch();
    int c0;
    c0 = n_con;
    hpd_in = 1'b1; tick(HS - 1);
    hpd_in = 1'b0; tick(HL + 5);
    chk("R4 no connect on short high", n_con - c0, 0);
    chk("R4 level stays low", int'(hpd_level), 0);
  endtask

  task automatic t_connect(input logic sel, input int n);
    hi_db_sel = sel;
    hpd_in = 1'b1;
    tick(n + 1);
    chk(sel ? "R3 long: no connect early" : "R2 no connect early", int'(connect_pulse), 0);
    chk("R2 level low before due", int'(hpd_level), 0);
    tick(1);
    chk(sel ? "R3 long: connect due" : "R3 short: connect due", int'(connect_pulse), 1);
    chk("R2 level rises", int'(hpd_level), 1);
    tick(1);
    chk("R8 connect one cycle", int'(connect_pulse), 0);
  endtask

  task automatic t_irq(input int len);
    int i0;
    i0 = n_irq;
    hpd_in = 1'b0; tick(len);
    hpd_in = 1'b1; tick(2);
    chk("R5 irq not yet", int'(irq_pulse), 0);
    tick(1);
    chk("R5 irq due", int'(irq_pulse), 1);
    chk("R5 level held", int'(hpd_level), 1);
    tick(1);
    chk("R8 irq one cycle", int'(irq_pulse), 0);
    chk("R9 one irq per dip", n_irq - i0, 1);
  endtask

  task automatic t_mid_low(input int len);
    int i0, d0;
    i0 = n_irq; d0 = n_dis;
    hpd_in = 1'b0; tick(len);
    hpd_in = 1'b1; tick(6);
    chk("R6 no irq on long dip", n_irq - i0, 0);
    chk("R6 no disconnect", n_dis - d0, 0);
    chk("R6 level held", int'(hpd_level), 1);
  endtask

  task automatic t_disconnect();
    hpd_in = 1'b0;
    tick(LDB + 1);
    chk("R7 no disconnect early", int'(disconnect_pulse), 0);
    chk("R7 level high before due", int'(hpd_level), 1);
    tick(1);
    chk("R7 disconnect due", int'(disconnect_pulse), 1);
    chk("R7 level falls", int'(hpd_level), 0);
    tick(1);
    chk("R8 disconnect one cycle", int'(disconnect_pulse), 0);
  endtask

  initial begin
    while (cyc < 20000) @(negedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    summary();
  end

  initial begin
    t_reset();
    t_glitch();
    t_connect(1'b0, HS);
    t_irq(3);
    t_irq(IRQ - 1);
    t_irq(1);
    t_mid_low(IRQ);
    t_mid_low(LDB - 1);
    t_disconnect();
    tick(5);
    chk("R9 no irq while down", n_irq, 3);
    t_connect(1'b1, HL);
    t_disconnect();
    tick(3);
    chk("R8 no overlapping strobes", n_overlap, 0);
    chk("R8 connect total", n_con, 2);
    chk("R8 disconnect total", n_dis, 2);
    summary();
  end
endmodule